// File: doc/BRIEF.md
# Dual-Sided Mailbox Unit

This block carries 32-bit words between two processors, called side A and side B. Each side has its own word-wide register port with a valid strobe, a write flag, a byte address and write data. Read data comes back combinationally in the same cycle as the read strobe, and the side effects of the access take effect at the next clock edge. Each side sees four transmit slots, four receive slots, a status word and a control word. A word that one side places in transmit slot n shows up in receive slot n of the other side.

Each slot and direction has one message-pending condition. The sender sees it as a cleared transmit-empty flag, and the receiver sees it as a set receive-full flag. Per-slot enables in each side's control word combine these flags into one level interrupt per side. The flag and enable bits are packed in reverse slot order. A zero written to side A's control word also wipes side B's control word.

Top module: `mbx_unit`

## Requirements
- R1: After reset, the status word of both sides reads 0x00F00000 (every transmit-empty flag set, no receive-full flag), both control words read 0, and both interrupts are low.
- R2: Address bits 5:2 select the word. Transmit slot n is at byte offset 4·n, receive slot n is at 0x10 + 4·n, the status word is at 0x20 and the control word is at 0x24. Address bits 1:0 are ignored.
- R3: A write to transmit slot n while that slot's transmit-empty flag is set takes effect from the next cycle: the writer's transmit-empty flag n clears, the peer's receive-full flag n sets, and the word is latched into the peer's receive slot n.
- R4: A read of receive slot n returns the latched word. From the next cycle, that side's receive-full flag n is clear and the peer's transmit-empty flag n is set again.
- R5: For slot n, the transmit-empty flag is status bit 23−n and the receive-full flag is status bit 27−n. The transmit enable is control bit 23−n and the receive enable is control bit 27−n.
- R6: A side's interrupt is high exactly when some slot n has both its transmit-empty flag and transmit enable set, or both its receive-full flag and receive enable set.
- R7: A write to a transmit slot whose transmit-empty flag is clear is ignored, and the pending word stays unchanged.
- R8: Writes to receive-slot offsets and to the status offset change no flag and no stored word.
- R9: A write of zero by side A to its control word clears the control words of both sides. Any other control write by side A, and every control write by side B (zero included), changes only the writer's own control word.
- R10: Reads of transmit offsets and of offsets above 0x24 return zero. Status and control bits outside the flag and enable fields read zero, and control write bits outside those fields are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aValid | input | 1 | Side A access strobe |
| aWrite | input | 1 | Side A access is a write when high |
| aAddr | input | 6 | Side A byte address |
| aWData | input | 32 | Side A write data |
| aRData | output | 32 | Side A read data, same cycle |
| aIrq | output | 1 | Side A interrupt |
| bValid | input | 1 | Side B access strobe |
| bWrite | input | 1 | Side B access is a write when high |
| bAddr | input | 6 | Side B byte address |
| bWData | input | 32 | Side B write data |
| bRData | output | 32 | Side B read data, same cycle |
| bIrq | output | 1 | Side B interrupt |

## Verification
The hardest situation to reach is a mix of flags in which the interrupt depends on the reverse bit packing. Some slots must be pending in each direction while the rest are empty, and only then does the full enable space show whether each enable bit is wired to the right slot. To get there, the stimulus first posts words into chosen slots from both sides and leaves them unread. It then sweeps all 256 control values on each side and compares the interrupt pins with the value computed from the mirrored flags. Because a zero written by side A also wipes side B's control word, the sweep on side A keeps disturbing side B, and the expected model has to follow that.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int unsigned SLOTS = 4;
  parameter int unsigned SIDES = 2;
  // word indices (address bits above the byte lane)
  localparam int unsigned TX_BASE  = 0;
  localparam int unsigned RX_BASE  = SLOTS;
  localparam int unsigned STAT_IDX = 2 * SLOTS;
  localparam int unsigned CTRL_IDX = 2 * SLOTS + 1;
  // low bit of each 4-bit flag / enable group
  localparam int unsigned TX_LSB   = 20;
  localparam int unsigned RX_LSB   = TX_LSB + SLOTS;

  typedef struct packed {
    logic [SIDES-1:0][SLOTS-1:0] latch;  // latch writer's data into peer receive slot
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SIDES-1:0]             busValid,
  input  logic [SIDES-1:0]             busWrite,
  input  logic [SIDES-1:0][ADDR_W-1:0] busAddr,
  input  logic [SIDES-1:0][DATA_W-1:0] busWData,
  output mbxStrobe_t                   strobe,
  output logic [SIDES-1:0][DATA_W-1:0] statusWord,
  output logic [SIDES-1:0][DATA_W-1:0] ctrlWord,
  output logic [SIDES-1:0]             irq
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  // pending[s][n]: side s has posted a word in slot n not yet read by its peer
  logic [SIDES-1:0][SLOTS-1:0] pending;
  logic [SIDES-1:0][SLOTS-1:0] txEnSlot;
  logic [SIDES-1:0][SLOTS-1:0] rxEnSlot;

  logic [SIDES-1:0][SLOTS-1:0] txWr;
  logic [SIDES-1:0][SLOTS-1:0] rxRd;
  logic [SIDES-1:0][SLOTS-1:0] accept;
  logic [SIDES-1:0]            ctrlWr;
  logic                        clearAll;

  always_comb begin
    for (int s = 0; s < SIDES; s++) begin
      ctrlWr[s] = busValid[s] && busWrite[s] &&
                  (busAddr[s][ADDR_W-1:2] == WIDX_W'(CTRL_IDX));
      for (int n = 0; n < SLOTS; n++) begin
        txWr[s][n]   = busValid[s] && busWrite[s] &&
                       (busAddr[s][ADDR_W-1:2] == WIDX_W'(TX_BASE + n));
        rxRd[s][n]   = busValid[s] && !busWrite[s] &&
                       (busAddr[s][ADDR_W-1:2] == WIDX_W'(RX_BASE + n));
        accept[s][n] = txWr[s][n] && !pending[s][n];
      end
    end
    clearAll = ctrlWr[0] && (busWData[0] == '0);
    strobe.latch = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      txEnSlot <= '0;
      rxEnSlot <= '0;
    end else begin
      for (int s = 0; s < SIDES; s++) begin
        for (int n = 0; n < SLOTS; n++) begin
          if (accept[s][n])
            pending[s][n] <= 1'b1;
          else if (rxRd[SIDES-1-s][n])
            pending[s][n] <= 1'b0;
        end
      end
      if (clearAll) begin
        txEnSlot <= '0;
        rxEnSlot <= '0;
      end else begin
        for (int s = 0; s < SIDES; s++) begin
          if (ctrlWr[s]) begin
            for (int n = 0; n < SLOTS; n++) begin
              txEnSlot[s][n] <= busWData[s][TX_LSB + SLOTS - 1 - n];
              rxEnSlot[s][n] <= busWData[s][RX_LSB + SLOTS - 1 - n];
            end
          end
        end
      end
    end
  end

  // status / control images and interrupt, reverse slot packing
  always_comb begin
    for (int s = 0; s < SIDES; s++) begin
      statusWord[s] = '0;
      ctrlWord[s]   = '0;
      irq[s]        = 1'b0;
      for (int n = 0; n < SLOTS; n++) begin
        statusWord[s][TX_LSB + SLOTS - 1 - n] = !pending[s][n];
        statusWord[s][RX_LSB + SLOTS - 1 - n] = pending[SIDES-1-s][n];
        ctrlWord[s][TX_LSB + SLOTS - 1 - n]   = txEnSlot[s][n];
        ctrlWord[s][RX_LSB + SLOTS - 1 - n]   = rxEnSlot[s][n];
        irq[s] = irq[s] | (!pending[s][n] && txEnSlot[s][n])
                        | (pending[SIDES-1-s][n] && rxEnSlot[s][n]);
      end
    end
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  mbxStrobe_t                   strobe,
  input  logic [SIDES-1:0][ADDR_W-1:0] busAddr,
  input  logic [SIDES-1:0][DATA_W-1:0] busWData,
  input  logic [SIDES-1:0][DATA_W-1:0] statusWord,
  input  logic [SIDES-1:0][DATA_W-1:0] ctrlWord,
  output logic [SIDES-1:0][DATA_W-1:0] busRData
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  // rxData[s][n]: word waiting in side s receive slot n
  logic [SIDES-1:0][SLOTS-1:0][DATA_W-1:0] rxData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
    end else begin
      for (int s = 0; s < SIDES; s++)
        for (int n = 0; n < SLOTS; n++)
          if (strobe.latch[s][n])
            rxData[SIDES-1-s][n] <= busWData[s];
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [WIDX_W-1:0] wordIdx;
    assign wordIdx = busAddr[s][ADDR_W-1:2];
    always_comb begin
      busRData[s] = '0;
      for (int n = 0; n < SLOTS; n++)
        if (wordIdx == WIDX_W'(RX_BASE + n))
          busRData[s] = rxData[s][n];
      if (wordIdx == WIDX_W'(STAT_IDX))
        busRData[s] = statusWord[s];
      if (wordIdx == WIDX_W'(CTRL_IDX))
        busRData[s] = ctrlWord[s];
    end
  end
endmodule

// File: rtl/mbx_unit.sv
module mbx_unit
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  input  logic              aWrite,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWData,
  output logic [DATA_W-1:0] aRData,
  output logic              aIrq,
  input  logic              bValid,
  input  logic              bWrite,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWData,
  output logic [DATA_W-1:0] bRData,
  output logic              bIrq
);
  logic [SIDES-1:0]             busValid;
  logic [SIDES-1:0]             busWrite;
  logic [SIDES-1:0][ADDR_W-1:0] busAddr;
  logic [SIDES-1:0][DATA_W-1:0] busWData;
  logic [SIDES-1:0][DATA_W-1:0] busRData;
  logic [SIDES-1:0][DATA_W-1:0] statusWord;
  logic [SIDES-1:0][DATA_W-1:0] ctrlWord;
  logic [SIDES-1:0]             irq;
  mbxStrobe_t                   strobe;

  assign busValid = {bValid, aValid};
  assign busWrite = {bWrite, aWrite};
  assign busAddr  = {bAddr, aAddr};
  assign busWData = {bWData, aWData};
  assign aRData   = busRData[0];
  assign bRData   = busRData[1];
  assign aIrq     = irq[0];
  assign bIrq     = irq[1];

  mbx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .strobe(strobe),
    .statusWord(statusWord), .ctrlWord(ctrlWord), .irq(irq)
  );

  mbx_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWData(busWData), .statusWord(statusWord), .ctrlWord(ctrlWord),
    .busRData(busRData)
  );
endmodule

// File: rtl/mbx_unit_chk.sv
module mbx_unit_chk
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         aValid,
  input logic                         aWrite,
  input logic [ADDR_W-1:0]            aAddr,
  input logic [DATA_W-1:0]            aWData,
  input logic [DATA_W-1:0]            aRData,
  input logic                         aIrq,
  input logic                         bValid,
  input logic                         bWrite,
  input logic [ADDR_W-1:0]            bAddr,
  input logic [SIDES-1:0][DATA_W-1:0] statusWord,
  input logic [SIDES-1:0][DATA_W-1:0] ctrlWord
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  for (genvar n = 0; n < SLOTS; n++) begin : g_slot
    localparam int unsigned TB = TX_LSB + SLOTS - 1 - n;
    localparam int unsigned RB = RX_LSB + SLOTS - 1 - n;

    // R3
    post_sets_full_chk: assert property (@(posedge clk) disable iff (!rstN)
      (aValid && aWrite && aAddr[ADDR_W-1:2] == WIDX_W'(TX_BASE + n) && statusWord[0][TB])
      |=> (statusWord[1][RB] && !statusWord[0][TB]));

    // R7
    busy_post_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
      (aValid && aWrite && aAddr[ADDR_W-1:2] == WIDX_W'(TX_BASE + n) && !statusWord[0][TB]
       && !(bValid && !bWrite && bAddr[ADDR_W-1:2] == WIDX_W'(RX_BASE + n)))
      |=> statusWord[1][RB]);

    // R4
    read_frees_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
      (bValid && !bWrite && bAddr[ADDR_W-1:2] == WIDX_W'(RX_BASE + n)
       && !(aValid && aWrite && aAddr[ADDR_W-1:2] == WIDX_W'(TX_BASE + n) && statusWord[0][TB]))
      |=> (statusWord[0][TB] && !statusWord[1][RB]));
  end

  // R9
  ctrl_clear_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && aWrite && aAddr[ADDR_W-1:2] == WIDX_W'(CTRL_IDX) && aWData == '0)
    |=> (ctrlWord[0] == '0 && ctrlWord[1] == '0));

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[0] == '0) |-> !aIrq);

  // R10
  unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && !aWrite && aAddr[ADDR_W-1:2] > WIDX_W'(CTRL_IDX)) |-> (aRData == '0));
endmodule

bind mbx_unit mbx_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .aValid(aValid), .aWrite(aWrite), .aAddr(aAddr),
  .aWData(aWData), .aRData(aRData), .aIrq(aIrq), .bValid(bValid),
  .bWrite(bWrite), .bAddr(bAddr), .statusWord(statusWord), .ctrlWord(ctrlWord)
);

// File: tb/mbx_unit_tb_top.sv
module mbx_unit_tb_top;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vValid [2];
  logic        vWrite [2];
  logic [5:0]  vAddr  [2];
  logic [31:0] vWData [2];
  logic [31:0] aRData, bRData;
  logic        aIrq, bIrq;

  int checks = 0;
  int fails  = 0;

  // bench model
  bit          pend [2][4];   // pend[s][n]: side s posted slot n, unread
  logic [31:0] rxm  [2][4];
  bit          txe  [2][4];
  bit          rxe  [2][4];

  always #(CLK_P/2) clk = ~clk;

  mbx_unit dut_i (
    .clk(clk), .rstN(rstN),
    .aValid(vValid[0]), .aWrite(vWrite[0]), .aAddr(vAddr[0]), .aWData(vWData[0]),
    .aRData(aRData), .aIrq(aIrq),
    .bValid(vValid[1]), .bWrite(vWrite[1]), .bAddr(vAddr[1]), .bWData(vWData[1]),
    .bRData(bRData), .bIrq(bIrq)
  );

  function automatic logic [31:0] expStatus(int s);
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[23-n] = !pend[s][n];
      v[27-n] = pend[1-s][n];
    end
    return v;
  endfunction

  function automatic logic [31:0] expCtrl(int s);
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[23-n] = txe[s][n];
      v[27-n] = rxe[s][n];
    end
    return v;
  endfunction

  function automatic logic expIrq(int s);
    logic r = 1'b0;
    for (int n = 0; n < 4; n++)
      r = r | (!pend[s][n] && txe[s][n]) | (pend[1-s][n] && rxe[s][n]);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busOp(int s, bit wr, logic [5:0] addr, logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    vValid[s] = 1'b1; vWrite[s] = wr; vAddr[s] = addr; vWData[s] = wd;
    #1;
    rd = (s == 0) ? aRData : bRData;
    @(posedge clk);
    #1;
    vValid[s] = 1'b0; vWrite[s] = 1'b0;
  endtask

  task automatic wr(int s, logic [5:0] addr, logic [31:0] d);
    logic [31:0] rd;
    int idx = int'(addr[5:2]);
    busOp(s, 1'b1, addr, d, rd);
    if (idx < 4) begin
      if (!pend[s][idx]) begin
        pend[s][idx] = 1'b1;
        rxm[1-s][idx] = d;
      end
    end else if (idx == 9) begin
      if (s == 0 && d == 0) begin
        for (int k = 0; k < 2; k++)
          for (int n = 0; n < 4; n++) begin txe[k][n] = 0; rxe[k][n] = 0; end
      end else begin
        for (int n = 0; n < 4; n++) begin txe[s][n] = d[23-n]; rxe[s][n] = d[27-n]; end
      end
    end
  endtask

  task automatic rdChk(int s, logic [5:0] addr, string req);
    logic [31:0] rd, exp;
    int idx = int'(addr[5:2]);
    exp = '0;
    if (idx >= 4 && idx < 8) exp = rxm[s][idx-4];
    else if (idx == 8) exp = expStatus(s);
    else if (idx == 9) exp = expCtrl(s);
    busOp(s, 1'b0, addr, 32'h0, rd);
    check(req, rd, exp);
    if (idx >= 4 && idx < 8) pend[1-s][idx-4] = 1'b0;
  endtask

  task automatic irqChk(string req);
    @(negedge clk);
    #1;
    check(req, {31'b0, aIrq}, {31'b0, expIrq(0)});
    check(req, {31'b0, bIrq}, {31'b0, expIrq(1)});
  endtask

  task automatic ctrlSweep(string req);
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 256; e++) begin
        wr(s, 6'h24, 32'(e) << 20);
        irqChk(req);
      end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      vValid[s] = 0; vWrite[s] = 0; vAddr[s] = '0; vWData[s] = '0;
      for (int n = 0; n < 4; n++) begin
        pend[s][n] = 0; rxm[s][n] = '0; txe[s][n] = 0; rxe[s][n] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1 statusA", expStatus(0), 32'h00F0_0000);
    rdChk(0, 6'h20, "R1"); rdChk(1, 6'h20, "R1");
    rdChk(0, 6'h24, "R1"); rdChk(1, 6'h24, "R1");
    irqChk("R1");

    // R2 R3 R4 R5 single-slot traffic in every slot both ways
    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 4; n++) begin
        logic [31:0] d = 32'hA5C3_0000 ^ (32'(s + 1) << 28) ^ (32'(n) * 32'h0101_1111);
        wr(s, 6'(4 * n), d);
        rdChk(s, 6'h20, "R3");
        rdChk(1 - s, 6'h20, "R5");
        rdChk(1 - s, 6'(16 + 4 * n), "R4");
        rdChk(1 - s, 6'h20, "R4");
        rdChk(s, 6'h20, "R4");
      end

    // R2 fill all slots (byte lane bits set), drain in reverse order
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) wr(s, 6'(4 * n + 3), 32'h5000_0000 + 32'(16 * s + n));
      rdChk(s, 6'h20, "R2"); rdChk(1 - s, 6'h20, "R2");
      for (int n = 3; n >= 0; n--) begin
        rdChk(1 - s, 6'(16 + 4 * n), "R2");
        rdChk(1 - s, 6'h20, "R5");
      end
    end

    // R7 overwrite of pending slot, R8 writes to receive/status offsets
    wr(0, 6'h04, 32'h1111_2222);
    wr(0, 6'h04, 32'h3333_4444);
    wr(1, 6'h14, 32'hDEAD_BEEF);
    wr(1, 6'h20, 32'hFFFF_FFFF);
    wr(0, 6'h20, 32'h0000_0000);
    rdChk(0, 6'h20, "R8"); rdChk(1, 6'h20, "R8");
    rdChk(1, 6'h14, "R7");
    rdChk(1, 6'h20, "R7");

    // R10 unused and transmit offsets read zero
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 16; w++)
        if (w < 4 || w > 9) rdChk(s, 6'(4 * w), "R10");

    // R9 / R10 control writes
    wr(0, 6'h24, 32'hFFFF_FFFF);
    wr(1, 6'h24, 32'h0A50_0000);
    rdChk(0, 6'h24, "R10"); rdChk(1, 6'h24, "R9");
    wr(1, 6'h24, 32'h0);
    rdChk(0, 6'h24, "R9"); rdChk(1, 6'h24, "R9");
    wr(1, 6'h24, 32'h0330_0000);
    wr(0, 6'h24, 32'h0);
    rdChk(0, 6'h24, "R9"); rdChk(1, 6'h24, "R9");

    // R6 enable sweep, all slots empty
    ctrlSweep("R6 empty");
    // R6 enable sweep with mixed pending slots both ways
    wr(0, 6'h00, 32'hC0DE_0000);
    wr(0, 6'h08, 32'hC0DE_0002);
    wr(1, 6'h04, 32'hC0DE_1001);
    wr(1, 6'h0C, 32'hC0DE_1003);
    ctrlSweep("R6 mixed");
    rdChk(0, 6'h20, "R5"); rdChk(1, 6'h20, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule